// File: doc/BRIEF.md
# Self-Test Conversion Range Watchdog

This block supervises the results of a converter self-test. Three test algorithms exist, each with a fixed number of steps. The supply test has 3 steps, the resistive-capacitive test has 19 and the capacitive test has 17. A sequencer issues test-conversion requests after the normal conversion chain finishes. In one-shot mode it issues a single step. In scan mode it issues every step of the chosen algorithm. The supply test always runs as one unbroken group of three steps, and functional conversions are held off while it runs.

Each converted result returns tagged with its algorithm and step. The checker compares the value against that algorithm's own lower and upper thresholds. When checking is enabled for that algorithm and the value falls outside the window, the checker sets a sticky error bit. It also records the failing value and, for the two non-supply algorithms, the failing step. Error bits drive a maskable interrupt. A supply error drives the critical fault line, and the other two algorithms drive the non-critical line.

The sequencer has three states. SQ_IDLE moves to SQ_ISSUE when `chain_done` is seen with a valid algorithm selected. SQ_ISSUE always moves to SQ_WAIT. SQ_WAIT moves back to SQ_ISSUE, with the step advanced, when a result arrives before the last step. It moves to SQ_IDLE when the result of the last step arrives.

Top module: `stw_range_wdg`

## Requirements
- R1: After reset all error bits, `irq`, both fault lines, `eoc_flag`, `busy`, `func_hold` and `tst_req` are 0. Every algorithm starts with checking disabled, a lower threshold of 0 and an upper threshold of all ones.
- R2: Algorithms are encoded 0 = supply, 1 = resistive-capacitive and 2 = capacitive, and each has its own window. With checking enabled, a result sets bit [alg] of `err_flags` exactly when its value is below that algorithm's lower threshold or above its upper threshold. Values equal to either threshold are inside the window.
- R3: An algorithm whose enable bit is 0 never sets its error bit, whatever the value.
- R4: On a new error, the value is stored in `err_data` slice [alg*DATA_W +: DATA_W]. For algorithms 1 and 2 the step is stored in `err_step` slice [alg*5 +: 5]. The supply slice of `err_step` stays 0.
- R5: Only the first error per algorithm is captured. Later errors leave the step and data unchanged until a 1 on `err_clr[alg]` clears the bit. The next error after that is captured afresh.
- R6: `irq` is 1 exactly when some error bit is set together with its `irq_mask` bit.
- R7: `fault_crit` follows the supply error bit. `fault_ncf` is the OR of the other two error bits.
- R8: A tagged result sets `res_out_valid` for one cycle with `res_out_data` equal to the value. It also sets the sticky `eoc_flag`, which `eoc_clr` clears.
- R9: In one-shot mode (`scan_mode`=0), `chain_done` with algorithm 1 or 2 issues exactly one request for `sel_step`. A `sel_step` beyond the last step is reduced to the last step.
- R10: A supply run issues steps 0, 1 and 2 in either mode. `func_hold` is 1 from the first request until the third result arrives.
- R11: In scan mode, algorithms 1 and 2 issue every step from 0 to count-1 in ascending order: 19 steps and 17 steps respectively.
- R12: Results tagged with algorithm 3, or with a step at or beyond the algorithm's count, are ignored. They cause no error, no `res_out_valid` and no change to `eoc_flag`.
- R13: `tst_req` is a one-cycle pulse. The next request follows only after the previous step's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write threshold and enable of `cfg_alg` |
| cfg_alg | input | 2 | Algorithm being configured |
| cfg_lo | input | DATA_W | Lower threshold to write |
| cfg_hi | input | DATA_W | Upper threshold to write |
| cfg_en | input | 1 | Checking enable to write |
| irq_mask | input | 3 | Interrupt mask per algorithm |
| err_clr | input | 3 | Write-1-to-clear of error bits |
| eoc_clr | input | 1 | Clears `eoc_flag` |
| chain_done | input | 1 | Normal conversion chain has finished |
| scan_mode | input | 1 | 1 = scan all steps, 0 = one-shot |
| sel_alg | input | 2 | Algorithm to run |
| sel_step | input | 5 | Step for one-shot runs |
| tst_req | output | 1 | Test-conversion request pulse |
| tst_alg | output | 2 | Algorithm of the request |
| tst_step | output | 5 | Step of the request |
| func_hold | output | 1 | Blocks functional conversions during a supply run |
| busy | output | 1 | Sequencer run in progress |
| res_valid | input | 1 | Converted test result present |
| res_alg | input | 2 | Algorithm tag of the result |
| res_step | input | 5 | Step tag of the result |
| res_data | input | DATA_W | Converted value |
| res_out_valid | output | 1 | Accepted result, one-cycle pulse |
| res_out_data | output | DATA_W | Accepted result value |
| eoc_flag | output | 1 | Sticky end-of-conversion status |
| err_flags | output | 3 | Error bit per algorithm |
| err_step | output | 15 | Captured step per algorithm |
| err_data | output | 3*DATA_W | Captured value per algorithm |
| irq | output | 1 | Masked interrupt |
| fault_crit | output | 1 | Critical fault (supply) |
| fault_ncf | output | 1 | Non-critical fault (other algorithms) |

## Verification
Each algorithm gets its own offset window. A sweep of values is then sent through it: far below, one below, on, one above, middle, one below, on and one above the upper bound, and the maximum. This separates strict from inclusive comparison and shows that each algorithm uses its own window. Repeated errors without a clear show that capture keeps the first error. Masks set per algorithm and disabled algorithms show that the outputs are gated. Sequencer runs cover one-shot, clamped one-shot, both scans and supply in both modes. They tell apart single-step issue, full ordered scans and the held-off supply group.

// File: rtl/stw_pkg.sv
package stw_pkg;
    localparam int ALG_N  = 3;
    localparam int STEP_W = 5;

    typedef enum logic [1:0] {
        ALG_SUP = 2'd0,
        ALG_RC  = 2'd1,
        ALG_CAP = 2'd2
    } alg_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_st_e;

    function automatic logic [STEP_W-1:0] step_count(input logic [1:0] a);
        case (a)
            2'd0:    step_count = 5'd3;
            2'd1:    step_count = 5'd19;
            2'd2:    step_count = 5'd17;
            default: step_count = 5'd0;
        endcase
    endfunction
endpackage

// File: rtl/stw_thresh.sv
module stw_thresh
    import stw_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_alg,
    input  logic [DATA_W-1:0]       cfg_lo,
    input  logic [DATA_W-1:0]       cfg_hi,
    input  logic                    cfg_en,
    output logic [ALG_N*DATA_W-1:0] lo_flat,
    output logic [ALG_N*DATA_W-1:0] hi_flat,
    output logic [ALG_N-1:0]        en
);
    for (genvar g = 0; g < ALG_N; g++) begin : g_bank
        logic [DATA_W-1:0] lo_q, hi_q;
        logic              en_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '1;
                en_q <= 1'b0;
            end else if (cfg_we && cfg_alg == 2'(g)) begin
                lo_q <= cfg_lo;
                hi_q <= cfg_hi;
                en_q <= cfg_en;
            end
        end
        assign lo_flat[g*DATA_W +: DATA_W] = lo_q;
        assign hi_flat[g*DATA_W +: DATA_W] = hi_q;
        assign en[g] = en_q;
    end
endmodule

// File: rtl/stw_capture.sv
module stw_capture
    import stw_pkg::*;
#(
    parameter int DATA_W    = 10,
    parameter bit KEEP_STEP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [DATA_W-1:0] data,
    input  logic [STEP_W-1:0] step,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  logic              en,
    input  logic              clr,
    output logic              err_o,
    output logic [STEP_W-1:0] step_o,
    output logic [DATA_W-1:0] data_o
);
    logic              err_q;
    logic [STEP_W-1:0] step_q;
    logic [DATA_W-1:0] data_q;
    logic              outside, set_err, take;

    always_comb begin
        outside = (data < lo) || (data > hi);
        set_err = hit && en && outside;
        take    = set_err && (!err_q || clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            step_q <= '0;
            data_q <= '0;
        end else begin
            if (clr) err_q <= 1'b0;
            if (take) begin
                err_q  <= 1'b1;
                data_q <= data;
                step_q <= KEEP_STEP ? step : '0;
            end
        end
    end

    assign err_o  = err_q;
    assign step_o = step_q;
    assign data_o = data_q;

    // R5: a held error keeps its record
    p_keep_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !clr |=> err_q && $stable(step_q) && $stable(data_q));
    // R3: disabled slice never raises an error
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !err_q && !en |=> !err_q);
    // R2: boundary values are inside the window
    p_bound_inside_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !err_q && hit && (data == lo || data == hi) && lo <= hi |=> !err_q);
endmodule

// File: rtl/stw_seq.sv
module stw_seq
    import stw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chain_done,
    input  logic              scan_mode,
    input  logic [1:0]        sel_alg,
    input  logic [STEP_W-1:0] sel_step,
    input  logic              res_valid,
    output logic              tst_req,
    output logic [1:0]        tst_alg,
    output logic [STEP_W-1:0] tst_step,
    output logic              func_hold,
    output logic              busy
);
    seq_st_e           st_q, st_d;
    logic [1:0]        alg_q;
    logic [STEP_W-1:0] step_q, last_q;
    logic [STEP_W-1:0] cnt, first_s, last_s;
    logic              start, at_last;

    always_comb begin
        cnt   = step_count(sel_alg);
        start = chain_done && (sel_alg != 2'd3);
        if (sel_alg == ALG_SUP || scan_mode) begin
            first_s = '0;
            last_s  = STEP_W'(cnt - 5'd1);
        end else begin
            first_s = (sel_step >= cnt) ? STEP_W'(cnt - 5'd1) : sel_step;
            last_s  = first_s;
        end
        at_last = (step_q == last_q);
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE:  if (start) st_d = SQ_ISSUE;
            SQ_ISSUE: st_d = SQ_WAIT;
            SQ_WAIT:  if (res_valid) st_d = at_last ? SQ_IDLE : SQ_ISSUE;
            default:  st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            alg_q  <= '0;
            step_q <= '0;
            last_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == SQ_IDLE && start) begin
                alg_q  <= sel_alg;
                step_q <= first_s;
                last_q <= last_s;
            end else if (st_q == SQ_WAIT && res_valid && !at_last) begin
                step_q <= step_q + 5'd1;
            end
        end
    end

    always_comb begin
        tst_req   = (st_q == SQ_ISSUE);
        busy      = (st_q != SQ_IDLE);
        func_hold = busy && (alg_q == ALG_SUP);
        tst_alg   = alg_q;
        tst_step  = step_q;
    end

    // R13: request is a single-cycle pulse
    p_req_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        tst_req |=> !tst_req);
    // R9: requested step is always legal for its algorithm
    p_step_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tst_req |-> tst_step < step_count(tst_alg));
    // R10: supply hold starts with step 0 and persists until a result
    p_hold_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(func_hold) |-> tst_req && tst_step == 5'd0);
    p_hold_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        func_hold && !res_valid |=> func_hold);
endmodule

// File: rtl/stw_range_wdg.sv
module stw_range_wdg
    import stw_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_alg,
    input  logic [DATA_W-1:0]   cfg_lo,
    input  logic [DATA_W-1:0]   cfg_hi,
    input  logic                cfg_en,
    input  logic [2:0]          irq_mask,
    input  logic [2:0]          err_clr,
    input  logic                eoc_clr,
    input  logic                chain_done,
    input  logic                scan_mode,
    input  logic [1:0]          sel_alg,
    input  logic [4:0]          sel_step,
    output logic                tst_req,
    output logic [1:0]          tst_alg,
    output logic [4:0]          tst_step,
    output logic                func_hold,
    output logic                busy,
    input  logic                res_valid,
    input  logic [1:0]          res_alg,
    input  logic [4:0]          res_step,
    input  logic [DATA_W-1:0]   res_data,
    output logic                res_out_valid,
    output logic [DATA_W-1:0]   res_out_data,
    output logic                eoc_flag,
    output logic [2:0]          err_flags,
    output logic [14:0]         err_step,
    output logic [3*DATA_W-1:0] err_data,
    output logic                irq,
    output logic                fault_crit,
    output logic                fault_ncf
);
    logic [ALG_N*DATA_W-1:0] lo_flat, hi_flat;
    logic [ALG_N-1:0]        en;
    logic                    tag_ok;
    logic                    rv_q, eoc_q;
    logic [DATA_W-1:0]       rd_q;

    stw_thresh #(.DATA_W(DATA_W)) thresh_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_alg(cfg_alg),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_en(cfg_en),
        .lo_flat(lo_flat), .hi_flat(hi_flat), .en(en)
    );

    stw_seq seq_i (
        .clk(clk), .rst_n(rst_n), .chain_done(chain_done), .scan_mode(scan_mode),
        .sel_alg(sel_alg), .sel_step(sel_step), .res_valid(res_valid),
        .tst_req(tst_req), .tst_alg(tst_alg), .tst_step(tst_step),
        .func_hold(func_hold), .busy(busy)
    );

    assign tag_ok = res_valid && (res_alg != 2'd3) && (res_step < step_count(res_alg));

    for (genvar g = 0; g < ALG_N; g++) begin : g_cap
        stw_capture #(.DATA_W(DATA_W), .KEEP_STEP(g != 0)) cap_i (
            .clk(clk), .rst_n(rst_n),
            .hit(tag_ok && res_alg == 2'(g)),
            .data(res_data), .step(res_step),
            .lo(lo_flat[g*DATA_W +: DATA_W]), .hi(hi_flat[g*DATA_W +: DATA_W]),
            .en(en[g]), .clr(err_clr[g]),
            .err_o(err_flags[g]), .step_o(err_step[g*STEP_W +: STEP_W]),
            .data_o(err_data[g*DATA_W +: DATA_W])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rv_q  <= 1'b0;
            rd_q  <= '0;
            eoc_q <= 1'b0;
        end else begin
            rv_q <= tag_ok;
            if (tag_ok) rd_q <= res_data;
            if (tag_ok)       eoc_q <= 1'b1;
            else if (eoc_clr) eoc_q <= 1'b0;
        end
    end

    always_comb begin
        res_out_valid = rv_q;
        res_out_data  = rd_q;
        eoc_flag      = eoc_q;
        irq           = |(err_flags & irq_mask);
        fault_crit    = err_flags[0];
        fault_ncf     = err_flags[1] | err_flags[2];
    end

    // R12: results with an invalid algorithm tag are dropped
    p_bad_tag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_alg == 2'd3 |=> !res_out_valid);
    // R7: a critical fault only appears after a supply-tagged result
    p_crit_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_crit) |-> $past(res_valid && res_alg == 2'd0));
    // R8: eoc status rises only with an accepted result
    p_eoc_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_flag) |-> res_out_valid);
endmodule

// File: tb/stw_range_wdg_tb.sv
module stw_range_wdg_tb_top;
    localparam int DW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, cfg_en = 0, eoc_clr = 0, chain_done = 0, scan_mode = 0, res_valid = 0;
    logic [1:0] cfg_alg = 0, sel_alg = 0, res_alg = 0;
    logic [DW-1:0] cfg_lo = 0, cfg_hi = 0, res_data = 0;
    logic [2:0] irq_mask = 0, err_clr = 0;
    logic [4:0] sel_step = 0, res_step = 0;
    logic tst_req, func_hold, busy, res_out_valid, eoc_flag, irq, fault_crit, fault_ncf;
    logic [1:0] tst_alg;
    logic [4:0] tst_step;
    logic [DW-1:0] res_out_data;
    logic [2:0] err_flags;
    logic [14:0] err_step;
    logic [3*DW-1:0] err_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    stw_range_wdg #(.DATA_W(DW)) dut_i (.*);

    function automatic int cnt_of(int a);
        return (a == 0) ? 3 : (a == 1) ? 19 : 17;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(int a, int lo, int hi, int e);
        cfg_we = 1; cfg_alg = 2'(a); cfg_lo = DW'(lo); cfg_hi = DW'(hi); cfg_en = 1'(e);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic send(int a, int s, int d);
        res_valid = 1; res_alg = 2'(a); res_step = 5'(s); res_data = DW'(d);
        @(negedge clk);
        res_valid = 0;
    endtask

    task automatic clr(int m);
        err_clr = 3'(m);
        @(negedge clk);
        err_clr = 0;
    endtask

    task automatic run_seq(int a, int scan, int sel, int first, int n);
        sel_alg = 2'(a); scan_mode = 1'(scan); sel_step = 5'(sel); chain_done = 1;
        @(negedge clk);
        chain_done = 0;
        for (int k = 0; k < n; k++) begin
            chk("R13 req present", int'(tst_req), 1);
            chk("R9/R11 req alg", int'(tst_alg), a);
            chk("R9/R11 req step", int'(tst_step), first + k);
            chk("R10 hold level", int'(func_hold), (a == 0) ? 1 : 0);
            @(negedge clk);
            chk("R13 single pulse", int'(tst_req), 0);
            res_valid = 1; res_alg = tst_alg; res_step = tst_step; res_data = DW'(150);
            @(negedge clk);
            res_valid = 0;
        end
        chk("R9 run ends busy", int'(busy), 0);
        chk("R13 no extra req", int'(tst_req), 0);
        chk("R10 hold released", int'(func_hold), 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 err_flags", int'(err_flags), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 faults", int'({fault_crit, fault_ncf}), 0);
        chk("R1 eoc", int'(eoc_flag), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 hold", int'(func_hold), 0);
        chk("R1 req", int'(tst_req), 0);
        send(0, 0, 1023);
        chk("R1 disabled at reset", int'(err_flags), 0);
        chk("R8 out valid", int'(res_out_valid), 1);
        chk("R8 out data", int'(res_out_data), 1023);
        chk("R8 eoc set", int'(eoc_flag), 1);
        eoc_clr = 1; @(negedge clk); eoc_clr = 0;
        chk("R8 eoc cleared", int'(eoc_flag), 0);
        chk("R8 pulse ends", int'(res_out_valid), 0);

        // R2/R4/R6/R7 window sweep per algorithm, separate windows
        irq_mask = 3'b111;
        for (int a = 0; a < 3; a++) cfg(a, 100 + 10 * a, 200 + 10 * a, 1);
        for (int a = 0; a < 3; a++) begin
            int lo = 100 + 10 * a;
            int hi = 200 + 10 * a;
            int vals[9] = '{0, lo - 1, lo, lo + 1, (lo + hi) / 2, hi - 1, hi, hi + 1, 1023};
            for (int i = 0; i < 9; i++) begin
                int v = vals[i];
                int st = i % cnt_of(a);
                int e = (v < lo || v > hi) ? 1 : 0;
                send(a, st, v);
                chk("R2 err bit", int'(err_flags[a]), e);
                chk("R2 other bits", int'(err_flags & ~(3'b1 << a)), 0);
                chk("R6 irq", int'(irq), e);
                chk("R7 crit", int'(fault_crit), (a == 0) ? e : 0);
                chk("R7 ncf", int'(fault_ncf), (a != 0) ? e : 0);
                if (e == 1) begin
                    chk("R4 data", int'(err_data[a*DW +: DW]), v);
                    chk("R4 step", int'(err_step[a*5 +: 5]), (a == 0) ? 0 : st);
                    clr(1 << a);
                    chk("R5 clear", int'(err_flags[a]), 0);
                end
            end
        end

        // R3 disable
        cfg(1, 100, 200, 0);
        send(1, 2, 5);
        chk("R3 disabled no err", int'(err_flags), 0);
        cfg(1, 110, 210, 1);

        // R5 first error kept
        send(2, 4, 5);
        send(2, 9, 900);
        chk("R5 still set", int'(err_flags[2]), 1);
        chk("R5 step kept", int'(err_step[10 +: 5]), 4);
        chk("R5 data kept", int'(err_data[2*DW +: DW]), 5);
        clr(4);
        send(2, 9, 900);
        chk("R5 recaptured step", int'(err_step[10 +: 5]), 9);
        chk("R5 recaptured data", int'(err_data[2*DW +: DW]), 900);

        // R6 mask
        irq_mask = 3'b011; @(negedge clk);
        chk("R6 masked", int'(irq), 0);
        irq_mask = 3'b100; @(negedge clk);
        chk("R6 unmasked", int'(irq), 1);
        clr(4);
        chk("R6 irq after clear", int'(irq), 0);

        // R12 bad tags
        send(0, 3, 0);
        chk("R12 step beyond count err", int'(err_flags), 0);
        chk("R12 step beyond count valid", int'(res_out_valid), 0);
        chk("R12 eoc unchanged", int'(eoc_flag), 1);
        eoc_clr = 1; @(negedge clk); eoc_clr = 0;
        send(3, 0, 0);
        chk("R12 alg3 err", int'(err_flags), 0);
        chk("R12 alg3 valid", int'(res_out_valid), 0);
        chk("R12 alg3 eoc", int'(eoc_flag), 0);
        send(2, 17, 0);
        chk("R12 cap step 17", int'(err_flags), 0);

        // Sequencer
        run_seq(1, 0, 7, 7, 1);      // R9 one-shot
        run_seq(2, 0, 30, 16, 1);    // R9 clamp
        run_seq(0, 0, 1, 0, 3);      // R10 supply one-shot
        run_seq(0, 1, 0, 0, 3);      // R10 supply scan
        run_seq(1, 1, 0, 0, 19);     // R11 scan RC
        run_seq(2, 1, 5, 0, 17);     // R11 scan CAP
        chk("R9 window results no error", int'(err_flags), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule